// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial port that moves one byte at a time over a single data line while it drives the shift clock itself. The shift rate is a fixed division of the core clock: one bit takes twelve core cycles. Software starts a transmit by writing a byte into the buffer. Software starts a receive by setting the receive enable while the receive flag is clear. When a transfer finishes, a transmit-done flag or a receive-done flag is raised. Each flag stays set until it is cleared through its own clear strobe.

The data line is bidirectional. The block presents it as an input, an output and an output enable, and the pad ring joins the three into one pin. The output enable is high only while a byte is being sent, so during a receive the far end can drive the line. The shift clock idles high and pulses low once per bit. The block changes outgoing data at the start of the low half of the clock pulse. It samples incoming data on the edge where the shift clock rises.

Top module: `sync_shift_port`

## Requirements
- R1: A bit period lasts DIV = 12 core cycles. Within each period `sclk_o` is low for the first 6 cycles and high for the last 6. With no transfer active, `sclk_o` is high.
- R2: A `buf_wr` pulse sampled while idle starts a transmit. From the following cycle `dat_oe` is 1 and `sclk_o` is low.
- R3: A transmit puts the eight bits of `buf_wdata` on `dat_o`, bit 0 first. Each bit is held for its whole 12-cycle period, so bit k covers cycles 12k to 12k+11 after the accepting edge.
- R4: `ti` becomes 1 on the edge 96 cycles after the edge that accepted the write. On the same edge `dat_oe` returns to 0.
- R5: `dat_oe` is 1 only during a transmit. It is 0 while idle and during a receive.
- R6: When idle with `rx_en`=1 and `ri`=0, a receive starts. `dat_i` is sampled on the edge where `sclk_o` rises, which is 6 cycles into each bit period. The first sample becomes bit 0 of the byte.
- R7: On the edge that ends the eighth receive bit period, `ri` becomes 1 and `buf_rdata` takes the received byte. While `ri`=1 or `rx_en`=0, no receive starts: `sclk_o` stays high and `buf_rdata` keeps its value.
- R8: A `buf_wr` pulse during an active transfer is ignored. The byte being sent is unchanged.
- R9: A pulse on `ti_clr` or `ri_clr` clears the matching flag on the next edge.
- R10: If `buf_wr` and a receive start condition occur in the same idle cycle, the transmit wins.
- R11: After reset, `sclk_o`=1, `dat_oe`=0, `ti`=0, `ri`=0 and `buf_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_wr | input | 1 | Write strobe for the transmit buffer |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rdata | output | 8 | Last byte received |
| rx_en | input | 1 | Receive enable |
| ti_clr | input | 1 | Clear strobe for the transmit-done flag |
| ri_clr | input | 1 | Clear strobe for the receive-done flag |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-done flag |
| dat_i | input | 1 | Data line input from the pad |
| dat_o | output | 1 | Data line output to the pad |
| dat_oe | output | 1 | Data line output enable |
| sclk_o | output | 1 | Shift clock output |

## Verification
Random bytes are sent and received one after another. Comparing every bit of each random byte with the line separates an LSB-first order from an MSB-first one and a correct bit period from a wrong one. Directed cases send a second write in the middle of a transmit, to show whether a busy write is dropped. Other directed cases hold the receive enable high while the receive flag is set, and then with the enable low, to show whether the receive gate works. A write that arrives in the same cycle as a receive start shows which of the two has priority.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        SSP_IDLE = 2'd0,
        SSP_TX   = 2'd1,
        SSP_RX   = 2'd2
    } ssp_mode_e;

    typedef struct packed {
        ssp_mode_e mode;
        logic      ti;
        logic      ri;
    } ssp_ctl_t;
endpackage

// File: rtl/ssp_bit_timer.sv
module ssp_bit_timer #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic clk_low,
    output logic sample_tick,
    output logic end_tick
);
    localparam int CW   = $clog2(DIV);
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        end_tick    = run && (cnt_q == CW'(DIV - 1));
        sample_tick = run && (cnt_q == CW'(HALF - 1));
        clk_low     = run && (cnt_q < CW'(HALF));
        cnt_d       = (run && !end_tick) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: the phase count never passes the end of a bit period
    a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DIV - 1));
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NBITS-1:0] load_val,
    input  logic             tx_step,
    input  logic             rx_step,
    input  logic             bit_step,
    input  logic             din,
    output logic [NBITS-1:0] word_q,
    output logic             last_bit
);
    localparam int CW = $clog2(NBITS + 1);

    logic [NBITS-1:0] word_d;
    logic [CW-1:0]    cnt_d, cnt_q;

    always_comb begin
        word_d = word_q;
        cnt_d  = cnt_q;
        if (load) begin
            word_d = load_val;
            cnt_d  = '0;
        end else begin
            if (tx_step)  word_d = word_q >> 1;
            if (rx_step)  word_d = {din, word_q[NBITS-1:1]};
            if (bit_step) cnt_d  = cnt_q + 1'b1;
        end
        last_bit = (cnt_q == CW'(NBITS - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else begin
            word_q <= word_d;
            cnt_q  <= cnt_d;
        end
    end

    // R3: each finished bit period moves the bit index on by one
    a_r3_bit_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_step && !load) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int DIV   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_wr,
    input  logic [NBITS-1:0] buf_wdata,
    output logic [NBITS-1:0] buf_rdata,
    input  logic             rx_en,
    input  logic             ti_clr,
    input  logic             ri_clr,
    output logic             ti,
    output logic             ri,
    input  logic             dat_i,
    output logic             dat_o,
    output logic             dat_oe,
    output logic             sclk_o
);
    ssp_ctl_t         ctl_d, ctl_q;
    logic [NBITS-1:0] rxbuf_d, rxbuf_q;
    logic [NBITS-1:0] word;
    logic [NBITS-1:0] load_val;
    logic             load, run, clk_low, sample_tick, end_tick, last_bit, done;
    logic             tx_step, rx_step;

    assign run     = (ctl_q.mode != SSP_IDLE);
    assign done    = end_tick && last_bit;
    assign tx_step = end_tick && (ctl_q.mode == SSP_TX);
    assign rx_step = sample_tick && (ctl_q.mode == SSP_RX);

    ssp_bit_timer #(.DIV(DIV)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .clk_low     (clk_low),
        .sample_tick (sample_tick),
        .end_tick    (end_tick)
    );

    ssp_shifter #(.NBITS(NBITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .tx_step  (tx_step),
        .rx_step  (rx_step),
        .bit_step (end_tick),
        .din      (dat_i),
        .word_q   (word),
        .last_bit (last_bit)
    );

    always_comb begin
        ctl_d    = ctl_q;
        rxbuf_d  = rxbuf_q;
        load     = 1'b0;
        load_val = '0;
        if (ti_clr) ctl_d.ti = 1'b0;
        if (ri_clr) ctl_d.ri = 1'b0;
        case (ctl_q.mode)
            SSP_IDLE: begin
                if (buf_wr) begin
                    ctl_d.mode = SSP_TX;
                    load       = 1'b1;
                    load_val   = buf_wdata;
                end else if (rx_en && !ctl_q.ri) begin
                    ctl_d.mode = SSP_RX;
                    load       = 1'b1;
                end
            end
            SSP_TX: begin
                if (done) begin
                    ctl_d.mode = SSP_IDLE;
                    ctl_d.ti   = 1'b1;
                end
            end
            SSP_RX: begin
                if (done) begin
                    ctl_d.mode = SSP_IDLE;
                    ctl_d.ri   = 1'b1;
                    rxbuf_d    = word;
                end
            end
            default: ctl_d.mode = SSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '{mode: SSP_IDLE, ti: 1'b0, ri: 1'b0};
            rxbuf_q <= '0;
        end else begin
            ctl_q   <= ctl_d;
            rxbuf_q <= rxbuf_d;
        end
    end

    assign ti        = ctl_q.ti;
    assign ri        = ctl_q.ri;
    assign buf_rdata = rxbuf_q;
    assign dat_oe    = (ctl_q.mode == SSP_TX);
    assign dat_o     = dat_oe & word[0];
    assign sclk_o    = !clk_low;

    // R1: the shift clock rests high between transfers
    a_r1_idle_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == SSP_IDLE) |-> sclk_o);
    // R2: an idle write opens a transmit with the clock low and the pin driven
    a_r2_tx_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == SSP_IDLE && buf_wr) |=> (dat_oe && !sclk_o));
    // R4: the end of the eighth transmit bit raises ti and releases the pin
    a_r4_ti_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == SSP_TX && done) |=> (ti && !dat_oe));
    // R7: the end of the eighth receive bit raises ri and loads the buffer
    a_r7_ri_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == SSP_RX && done) |=> (ri && buf_rdata == $past(word)));
    // R7: a pending ri keeps the port idle unless a write arrives
    a_r7_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == SSP_IDLE && ctl_q.ri && !buf_wr) |=> (ctl_q.mode == SSP_IDLE));
    // R8: an active transfer runs to its end whatever the write strobe does
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done) |=> (ctl_q.mode == $past(ctl_q.mode)));
endmodule

// File: tb/sync_shift_port_tb.sv
module sync_shift_port_tb;
    localparam int DIV  = 12;
    localparam int HALF = DIV / 2;
    localparam int LEN  = 8 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic [7:0] buf_rdata;
    logic       rx_en = 1'b0;
    logic       ti_clr = 1'b0;
    logic       ri_clr = 1'b0;
    logic       ti, ri;
    logic       dat_i = 1'b1;
    logic       dat_o, dat_oe, sclk_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sync_shift_port u_dut (
        .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .rx_en(rx_en), .ti_clr(ti_clr), .ri_clr(ri_clr),
        .ti(ti), .ri(ri), .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe),
        .sclk_o(sclk_o)
    );

    function automatic logic exp_sclk(input int c);
        return ((c % DIV) >= HALF);
    endfunction

    function automatic logic exp_bit(input logic [7:0] v, input int c);
        return v[c / DIV];
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic clear_ti();
        ti_clr = 1'b1;
        @(negedge clk);
        ti_clr = 1'b0;
        chk(ti == 1'b0, "R9", "ti after clear", ti, 0);
    endtask

    task automatic clear_ri();
        ri_clr = 1'b1;
        @(negedge clk);
        ri_clr = 1'b0;
        chk(ri == 1'b0, "R9", "ri after clear", ri, 0);
    endtask

    // junk_at < 0 means no extra write during the transfer
    task automatic do_tx(input logic [7:0] v, input int junk_at, input logic also_rx);
        @(negedge clk);
        buf_wr = 1'b1;
        buf_wdata = v;
        rx_en = also_rx;
        @(negedge clk);
        buf_wr = 1'b0;
        rx_en = 1'b0;
        if (also_rx) chk(dat_oe == 1'b1, "R10", "tx wins over rx start", dat_oe, 1);
        chk(dat_oe && !sclk_o, "R2", "start oe/sclk", {dat_oe, sclk_o}, 2'b10);
        for (int c = 0; c < LEN; c++) begin
            buf_wr = 1'b0;
            chk(dat_o == exp_bit(v, c) && dat_oe, "R3", "tx bit", {dat_oe, dat_o},
                {1'b1, exp_bit(v, c)});
            chk(sclk_o == exp_sclk(c), "R1", "tx sclk", sclk_o, exp_sclk(c));
            if (c == LEN - 1) chk(ti == 1'b0, "R4", "ti early", ti, 0);
            if (c == junk_at) begin
                buf_wr = 1'b1;
                buf_wdata = ~v;
            end
            @(negedge clk);
        end
        buf_wr = 1'b0;
        chk(ti == 1'b1, "R4", "ti at end", ti, 1);
        chk(dat_oe == 1'b0, "R4", "oe at end", dat_oe, 0);
        chk(sclk_o == 1'b1, "R1", "sclk after tx", sclk_o, 1);
        clear_ti();
    endtask

    task automatic do_rx(input logic [7:0] v, input logic keep_ri);
        logic [7:0] old;
        old = buf_rdata;
        @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
        rx_en = 1'b0;
        for (int c = 0; c < LEN; c++) begin
            dat_i = exp_bit(v, c);
            chk(dat_oe == 1'b0, "R5", "oe during rx", dat_oe, 0);
            chk(sclk_o == exp_sclk(c), "R6", "rx sclk", sclk_o, exp_sclk(c));
            if (c == LEN - 1)
                chk(ri == 1'b0 && buf_rdata == old, "R7", "ri/buffer early",
                    {ri, buf_rdata}, {1'b0, old});
            @(negedge clk);
        end
        dat_i = ~dat_i;
        chk(ri == 1'b1, "R7", "ri at end", ri, 1);
        chk(buf_rdata == v, "R6", "received byte", buf_rdata, v);
        if (!keep_ri) clear_ri();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        chk(sclk_o == 1'b1 && dat_oe == 1'b0 && ti == 1'b0 && ri == 1'b0 && buf_rdata == 8'h00,
            "R11", "reset state during reset",
            {sclk_o, dat_oe, ti, ri, buf_rdata}, {4'b1000, 8'h00});
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk_o == 1'b1 && dat_oe == 1'b0 && ti == 1'b0 && ri == 1'b0 && buf_rdata == 8'h00,
            "R11", "reset state after release",
            {sclk_o, dat_oe, ti, ri, buf_rdata}, {4'b1000, 8'h00});

        // directed corner bytes
        do_tx(8'h01, -1, 1'b0);
        do_tx(8'h80, -1, 1'b0);
        do_rx(8'hA5, 1'b0);
        // R8: a second write in the middle of a transmit is dropped
        do_tx(8'h3C, 40, 1'b0);
        do_tx(8'hC3, 0, 1'b0);

        // R7: a pending ri blocks a receive although the enable is set
        do_rx(8'h96, 1'b1);
        held = buf_rdata;
        rx_en = 1'b1;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            chk(sclk_o == 1'b1 && dat_oe == 1'b0, "R7", "no rx while ri set",
                {sclk_o, dat_oe}, 2'b10);
        end
        rx_en = 1'b0;
        chk(buf_rdata == held, "R7", "buffer kept while ri set", buf_rdata, held);
        clear_ri();
        // R7: the enable low also keeps the port idle
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            chk(sclk_o == 1'b1, "R7", "no rx while disabled", sclk_o, 1);
        end

        // R10: write and receive start in the same cycle
        do_tx(8'h5E, -1, 1'b1);
        chk(ri == 1'b0 && buf_rdata == held, "R10", "no rx after tie",
            {ri, buf_rdata}, {1'b0, held});

        // constrained random mix
        for (int n = 0; n < 8; n++) begin
            logic [7:0] v;
            v = 8'($urandom);
            if ($urandom % 2 == 0) do_tx(v, int'($urandom % 95), 1'b0);
            else                   do_rx(v, 1'b0);
        end
        finish_run();
    end
endmodule